// File: doc/BRIEF.md
# Serial Wiper Code Register with Two-Wire Slave Access

This block is a two-wire (I2C-compatible) bus slave that owns a single 7-bit wiper code. A bus master can set the code with a write transfer or fetch it with a read transfer. The code is brought out on a parallel port. A separate tap decoder uses it to choose one of 128 resistor taps. The bus lines are oversampled by a system clock at least 16 times faster than SCL. START and STOP are recognised from those samples. Data bits are taken on SCL rising edges. The slave changes its SDA drive only after SCL has fallen.

After reset the code sits at midscale. Once a master has addressed the slave for writing, every data byte it sends replaces the code, with no need to address the slave again. Bit 7 of each such byte is discarded. A read returns the code as a byte whose top bit is zero. The read continues for as long as the master acknowledges each byte. The slave uses the fixed 7-bit address 0101110. It stands aside from any transfer aimed at another address.

Top module: `i2c_wiper_slave`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) wiper_code equals 0x40 and sda_oe is 0.
- R2: An address byte carrying 0101110 in its first seven bits, with bit 8 = 0 for a write or 1 for a read, is acknowledged: SDA is held low during the high phase of the ninth SCL pulse.
- R3: An address byte with any other 7-bit address gets no acknowledge. sda_oe stays 0, and the data bytes that follow leave wiper_code unchanged until the next START.
- R4: In a write transfer, bits 6..0 of each completed data byte become wiper_code and bit 7 has no effect. The slave acknowledges the byte on the ninth SCL pulse.
- R5: Successive data bytes in one write transfer each update wiper_code in turn, without a new address byte.
- R6: In a read transfer the slave sends, most significant bit first, a 0 followed by bits 6..0 of wiper_code.
- R7: While the master acknowledges, read bytes keep coming and each repeats the current code. After a master no-acknowledge (SDA high on the ninth pulse) the slave releases SDA and stays idle.
- R8: START is a falling SDA while SCL is high, and STOP is a rising SDA while SCL is high. A START given at any point, including partway through a byte, begins a new address byte.
- R9: A STOP that arrives before the eighth bit of a data byte discards that partial byte, so wiper_code keeps its previous value.
- R10: sda_oe changes only while SCL is low, except when it is released at a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 leaves the line released |
| wiper_code | output | 7 | Current wiper code for the tap decoder |

## Verification
The write path gets a streamed sweep of all 128 codes in a single transfer. Bit 7 of each byte is toggled in a scrambled pattern, which separates a correct load from one that leaks the top bit or misses bytes after the first. Single-byte writes followed by three-byte reads (acknowledge, acknowledge, no-acknowledge) cover 16 spread codes. They show apart a read that stops early, a read that repeats stale data, and a read that holds the line after the no-acknowledge. Every single-bit corruption of the address is tried for both directions, which tests that the address compare covers every bit. Transfers cut short by a STOP or a START partway through a byte check that a partial byte is thrown away and that address reception starts again.

// File: rtl/i2cw_pkg.sv
// Shared types for the two-wire wiper slave.
// Assumes: nothing beyond the standard language.
package i2cw_pkg;

    // Protocol sequencer states
    typedef enum logic [2:0] {
        S_IDLE,      // waiting for START
        S_ADDR,      // shifting in the address byte
        S_ADDR_ACK,  // driving the address acknowledge
        S_WR,        // shifting in a data byte
        S_WR_ACK,    // driving the data acknowledge
        S_RD,        // shifting out a data byte
        S_RD_ACK,    // sampling the master acknowledge
        S_IGNORE     // not addressed; wait for START
    } link_state_t;

endpackage

// File: rtl/i2cw_line_sync.sv
// Multi-stage synchronizer for a group of asynchronous lines. It also
// keeps one more stage so that callers can detect edges.
// Assumes: inputs idle high (bus lines with pull-ups), so reset loads ones.
module i2cw_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] dprev
);

    logic [STAGES:0][WIDTH-1:0] chain_q;

    // Shift the lines through the synchronizer and edge stage
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-1:0], din};
    end

    assign dout  = chain_q[STAGES-1];
    assign dprev = chain_q[STAGES];

endmodule

// File: rtl/i2cw_wiper_reg.sv
// Holds the wiper code. Presets on reset and loads on a strobe.
// Assumes: load is a single-cycle pulse from the sequencer.
module i2cw_wiper_reg #(
    parameter int              CODE_W = 7,
    parameter logic [CODE_W-1:0] PRESET = 7'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] load_val,
    output logic [CODE_W-1:0] code
);

    // Keep the code, replacing it when a write byte completes
    always_ff @(posedge clk) begin
        if (!rst_n)    code <= PRESET;
        else if (load) code <= load_val;
    end

endmodule

// File: rtl/i2cw_link.sv
// Bus protocol sequencer: finds START and STOP, receives the address,
// and moves data bytes in both directions.
// Assumes: scl/sda are already synchronized; the system clock runs at
// least 16x SCL, so each SCL phase lasts several clock cycles.
module i2cw_link
    import i2cw_pkg::*;
#(
    parameter int              CODE_W   = 7,
    parameter logic [6:0]      DEV_ADDR = 7'b0101110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              scl_p,
    input  logic              sda_s,
    input  logic              sda_p,
    input  logic [CODE_W-1:0] wiper,
    output logic              wr_en,
    output logic [CODE_W-1:0] wr_data,
    output logic              sda_oe
);

    localparam int BYTE_W = CODE_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    link_state_t       state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              rw;
    logic              more;

    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic [BYTE_W-1:0] next_tx;

    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
    assign next_tx  = {1'b0, wiper};
    assign wr_data  = rx_sh[CODE_W-1:0];

    // Advance the transfer on bus events; START/STOP take priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            rx_sh  <= '0;
            tx_sh  <= '0;
            rw     <= 1'b0;
            more   <= 1'b0;
            wr_en  <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_ev) begin
                state  <= S_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_ev) begin
                state  <= S_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    S_ADDR, S_WR: begin
                        if (scl_rise && cnt != FULL) begin
                            rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == FULL) begin
                            cnt <= '0;
                            if (state == S_WR) begin
                                wr_en  <= 1'b1;
                                sda_oe <= 1'b1;
                                state  <= S_WR_ACK;
                            end else if (rx_sh[7:1] == DEV_ADDR) begin
                                rw     <= rx_sh[0];
                                sda_oe <= 1'b1;
                                state  <= S_ADDR_ACK;
                            end else begin
                                state  <= S_IGNORE;
                            end
                        end
                    end
                    S_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (rw) begin
                                tx_sh  <= next_tx;
                                sda_oe <= ~next_tx[BYTE_W-1];
                                state  <= S_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= S_WR;
                            end
                        end
                    end
                    S_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= S_WR;
                        end
                    end
                    S_RD: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == FULL) begin
                                cnt    <= '0;
                                sda_oe <= 1'b0;
                                state  <= S_RD_ACK;
                            end else begin
                                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    S_RD_ACK: begin
                        if (scl_rise) begin
                            more <= ~sda_s;
                        end else if (scl_fall) begin
                            if (more) begin
                                tx_sh  <= next_tx;
                                sda_oe <= ~next_tx[BYTE_W-1];
                                state  <= S_RD;
                            end else begin
                                state  <= S_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == S_ADDR && !sda_oe)); // R8
    AST_IGNORE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_IGNORE |-> !sda_oe); // R3
    AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s); // R10
    AST_RELEASE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> (!scl_s || $past(start_ev) || $past(stop_ev))); // R10
    AST_LOAD_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state == S_WR_ACK && sda_oe)); // R4
    AST_READ_MSB_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR_ACK && scl_fall && rw && !start_ev && !stop_ev)
        |=> (state == S_RD && sda_oe)); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL); // R5

endmodule

// File: rtl/i2c_wiper_slave.sv
// Top level: two-wire slave holding one wiper code for a tap decoder.
// Assumes: SDA is open-drain with an external pull-up; sda_oe = 1 pulls
// it low. clk runs at least 16x the SCL rate.
module i2c_wiper_slave #(
    parameter int                CODE_W      = 7,
    parameter logic [6:0]        DEV_ADDR    = 7'b0101110,
    parameter logic [CODE_W-1:0] PRESET      = 7'h40,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [CODE_W-1:0] wiper_code
);

    logic [1:0]        line_s, line_p;
    logic              wr_en;
    logic [CODE_W-1:0] wr_data;

    i2cw_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  (line_s),
        .dprev (line_p)
    );

    i2cw_link #(.CODE_W(CODE_W), .DEV_ADDR(DEV_ADDR)) u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (line_s[1]),
        .scl_p   (line_p[1]),
        .sda_s   (line_s[0]),
        .sda_p   (line_p[0]),
        .wiper   (wiper_code),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .sda_oe  (sda_oe)
    );

    i2cw_wiper_reg #(.CODE_W(CODE_W), .PRESET(PRESET)) u_wiper (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_en),
        .load_val (wr_data),
        .code     (wiper_code)
    );

    AST_RESET_PRESET: assert property (@(posedge clk)
        !rst_n |=> (wiper_code == PRESET && !sda_oe)); // R1

endmodule

// File: tb/tb_i2c_wiper_slave.sv
// Self-checking bench: acts as a bus master with a wired-AND SDA model.
module tb_i2c_wiper_slave;

    localparam int         Q    = 6;          // clocks per quarter SCL bit
    localparam logic [6:0] ADDR = 7'b0101110;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe;
    logic [6:0] wiper_code;
    wire        sda_bus = m_sda & ~sda_oe;

    int errors = 0;
    int checks = 0;
    int glitches = 0;
    logic oe_seen = 1'b0;
    logic oe_prev = 1'b0;
    logic [6:0] exp_code;
    logic done = 1'b0;

    always #4 clk = ~clk;

    i2c_wiper_slave dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .sda_oe     (sda_oe),
        .wiper_code (wiper_code)
    );

    // R10 monitor: drive changes while SCL high; also records any drive
    always @(posedge clk) begin
        if (rst_n) begin
            if (sda_oe !== oe_prev && m_scl) glitches++;
            if (sda_oe) oe_seen = 1'b1;
        end
        oe_prev = sda_oe;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b1; wait_q();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; wait_q();
            m_scl = 1'b1; wait_q(); wait_q();
            m_scl = 1'b0; wait_q();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        ack = ~sda_bus; wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        b = '0;
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wait_q();
            m_scl = 1'b1; wait_q();
            b = {b[6:0], sda_bus}; wait_q();
            m_scl = 1'b0; wait_q();
        end
        m_sda = ~give_ack; wait_q();
        m_scl = 1'b1; wait_q(); wait_q();
        m_scl = 1'b0; wait_q();
        m_sda = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] rb;
        logic [7:0] wb;
        logic [6:0] code;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        check(wiper_code == 7'h40, "R1 preset", wiper_code, 'h40);
        check(sda_oe == 1'b0, "R1 released", sda_oe, 0);
        exp_code = 7'h40;

        // R4/R5: stream all codes in one write transfer, bit 7 scrambled
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        check(ack, "R2 write address ack", ack, 1);
        for (int i = 0; i < 128; i++) begin
            wb = {1'(i[0] ^ i[3] ^ i[5]), 7'(i)};
            send_byte(wb, ack);
            exp_code = 7'(i);
            check(ack, "R4 data ack", ack, 1);
            check(wiper_code == exp_code, "R5 streamed update", wiper_code, exp_code);
        end
        bus_stop();

        // R6/R7: write then read three bytes (ack, ack, nack)
        for (int k = 0; k < 16; k++) begin
            code = 7'(k * 37 + 11);
            bus_start();
            send_byte({ADDR, 1'b0}, ack);
            send_byte({1'b1, code}, ack);   // R4: bit 7 ignored
            bus_stop();
            exp_code = code;
            check(wiper_code == exp_code, "R4 msb ignored", wiper_code, exp_code);
            bus_start();
            send_byte({ADDR, 1'b1}, ack);
            check(ack, "R2 read address ack", ack, 1);
            recv_byte(rb, 1'b1);
            check(rb == {1'b0, exp_code}, "R6 read byte", rb, {1'b0, exp_code});
            recv_byte(rb, 1'b1);
            check(rb == {1'b0, exp_code}, "R7 repeated read", rb, {1'b0, exp_code});
            recv_byte(rb, 1'b0);
            check(rb == {1'b0, exp_code}, "R7 last read", rb, {1'b0, exp_code});
            wait_q();
            check(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
            bus_stop();
        end

        // R3: every single-bit address error, both directions, no STOP between
        oe_seen = 1'b0;
        for (int j = 0; j < 7; j++) begin
            for (int d = 0; d < 2; d++) begin
                bus_start();
                send_byte({ADDR ^ 7'(1 << j), 1'(d)}, ack);
                check(!ack, "R3 no ack on mismatch", ack, 0);
                send_byte(8'h2A, ack);
                check(!ack, "R3 data ignored ack", ack, 0);
                check(wiper_code == exp_code, "R3 data ignored", wiper_code, exp_code);
            end
        end
        check(!oe_seen, "R3 never drove SDA", oe_seen, 0);

        // R8: START after ignored traffic restarts address reception
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        check(ack, "R8 ack after restart", ack, 1);
        send_byte(8'h33, ack);
        exp_code = 7'h33;
        check(wiper_code == exp_code, "R8 write after restart", wiper_code, exp_code);
        bus_stop();

        // R9: STOP partway through a data byte discards it
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        send_bits(8'h5A, 4);
        bus_stop();
        check(wiper_code == exp_code, "R9 partial byte dropped", wiper_code, exp_code);

        // R8: repeated START partway through a data byte, then read
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        send_bits(8'h7F, 5);
        bus_start();
        send_byte({ADDR, 1'b1}, ack);
        check(ack, "R8 ack after mid-byte start", ack, 1);
        recv_byte(rb, 1'b0);
        check(rb == {1'b0, exp_code}, "R8 read after mid-byte start", rb, {1'b0, exp_code});
        bus_stop();

        // R8: write then repeated START into a read
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        send_byte(8'h95, ack);
        exp_code = 7'h15;
        bus_start();
        send_byte({ADDR, 1'b1}, ack);
        recv_byte(rb, 1'b0);
        check(rb == {1'b0, exp_code}, "R8 repeated start read", rb, {1'b0, exp_code});
        bus_stop();

        // R10: no drive change seen while SCL high
        check(glitches == 0, "R10 drive timing", glitches, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule